// File: doc/BRIEF.md
# ADC Conversion Scan Sequencer

This block drives a successive-approximation A/D converter through a sequence of conversions. Software programs two byte-wide registers. The control register holds the trigger gate, the conversion clock divider, the run bit and the repeat choice. The mode register picks scan or single-channel operation, the first channel and how many channels, from one to four, form the group. When a run begins, the block hands the converter one channel at a time with a one-cycle start pulse. It waits for the converter's done pulse and stores the returned result in that channel's result register.

A run begins when software sets the run bit, or when an external or timer trigger pulse arrives while triggering is enabled. A single-channel run or a one-pass scan ends by itself and clears the run bit. A repeating scan cycles over the group until software clears the run bit or the standby input goes high. While a run is active, the block divides its clock into a conversion-clock enable, and the converter counts this enable to time each conversion.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control register reads 8'h07, the mode register reads 8'h00, all done flags are 0 and all results are 0.
- R2: Control bits 2:0 always read as 1, and writes to them have no effect.
- R3: While the run bit (control bit 4) is 1, `cclk_en` pulses once every 32, 16, 8 or 4 clocks for clock-select (control bits 6:5) values 00, 01, 10 and 11. It stays 0 while the run bit is 0.
- R4: With trigger enable (control bit 7) at 1, a pulse on `ext_trig` or `tmr_trig` starts a run as if the run bit had been written. With trigger enable at 0 the pulses are ignored, and a pulse that arrives during a run is also ignored.
- R5: Writing the control register with bit 4 = 1 from idle starts a run. Writing it with bit 4 = 0 stops the run at once: the run bit reads 0 and no further `conv_start` is issued.
- R6: With scan disabled (mode bit 7 = 0), exactly one conversion of the first channel is made, and the run bit then clears.
- R7: With scan enabled, the channels first, first+1, … (modulo 16) of the group are converted in that order, group size = mode bits 5:4 plus 1. In one-pass scan (control bit 3 = 0) the run bit clears after the last channel.
- R8: In repeating scan (control bit 3 = 1) the group is converted over and over until the run bit is cleared. A high `standby` clears the run bit on the next clock.
- R9: Control bit 3 has no effect while scan is disabled.
- R10: While the run bit is 1, writes to clock select, control bit 3 and the whole mode register are ignored. Trigger enable and the run bit stay writable.
- R11: Each done pulse stores `conv_data` in the current channel's result register and sets that channel's done flag. All done flags clear when a run starts. `rd_data` shows the result of channel `rd_ch`.
- R12: The mode register layout is bit 7 scan enable, bit 6 reads 0, bits 5:4 group size minus one, bits 3:0 first channel.
- R13: `conv_start` is a one-cycle pulse with `conv_ch` valid. The next one follows in the cycle after the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| standby | input | 1 | Forces the run bit to 0 |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control register, 1 the mode register |
| wr_data | input | 8 | Write data |
| ctrl_q | output | 8 | Control register readback |
| mode_q | output | 8 | Mode register readback |
| ext_trig | input | 1 | External trigger pulse |
| tmr_trig | input | 1 | Timer trigger pulse |
| cclk_en | output | 1 | Conversion clock enable |
| conv_start | output | 1 | Start pulse to the converter |
| conv_ch | output | 4 | Channel being converted |
| conv_done | input | 1 | Conversion complete pulse |
| conv_data | input | 10 | Conversion result |
| rd_ch | input | 4 | Result readback channel |
| rd_data | output | 10 | Result of channel `rd_ch` |
| done_flags | output | 16 | Per-channel result-written flags |

## Verification
The assertions check on every cycle that the start pulse lasts one cycle, that standby clears the run bit, that the conversion enable is silent when idle, that settings stay frozen during a run, that a disabled trigger cannot start a run, that a single-channel run ends on its done pulse and that each done pulse sets its channel's flag. The channel order in a scan, the wrap past channel 15, the divider period chosen by each clock-select code, the repetition of a repeating scan and the stored result values show up only in the bench scenarios. There, a behavioural model runs beside the design with a fixed-latency converter.

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
  parameter int NCH   = 16,
  parameter int RES_W = 10,
  localparam int CHW  = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             standby,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [7:0]       wr_data,
  output logic [7:0]       ctrl_q,
  output logic [7:0]       mode_q,
  input  logic             ext_trig,
  input  logic             tmr_trig,
  output logic             cclk_en,
  output logic             conv_start,
  output logic [CHW-1:0]   conv_ch,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_data,
  input  logic [CHW-1:0]   rd_ch,
  output logic [RES_W-1:0] rd_data,
  output logic [NCH-1:0]   done_flags
);

  logic             trg_en, start_q, cont, scan_en, busy_q;
  logic [1:0]       cks, grp, pos;
  logic [CHW-1:0]   first;
  logic [4:0]       div_cnt;
  logic [RES_W-1:0] res [NCH];

  wire wr_ctrl = wr_en & ~wr_sel;
  wire wr_mode = wr_en & wr_sel;
  wire stop    = standby | (wr_ctrl & ~wr_data[4]);
  wire trig    = trg_en & (ext_trig | tmr_trig);
  wire go      = ~stop & ~start_q & ((wr_ctrl & wr_data[4]) | trig);
  wire [1:0] grp_last = scan_en ? grp : 2'd0;
  wire last    = (pos == grp_last);
  wire [4:0] div_last = 5'd31 >> cks;

  assign cclk_en    = start_q & (div_cnt == div_last);
  assign conv_start = start_q & ~busy_q;
  assign conv_ch    = first + CHW'(pos);
  assign ctrl_q     = {trg_en, cks, start_q, cont, 3'b111};
  assign mode_q     = {scan_en, 1'b0, grp, 4'(first)};
  assign rd_data    = res[rd_ch];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trg_en <= 1'b0; cks <= '0; cont <= 1'b0;
      scan_en <= 1'b0; grp <= '0; first <= '0;
      start_q <= 1'b0; busy_q <= 1'b0; pos <= '0;
      div_cnt <= '0; done_flags <= '0;
      for (int i = 0; i < NCH; i++) res[i] <= '0;
    end else begin
      if (wr_ctrl) begin
        trg_en <= wr_data[7];
        if (!start_q) begin
          cks  <= wr_data[6:5];
          cont <= wr_data[3];
        end
      end
      if (wr_mode && !start_q) begin
        scan_en <= wr_data[7];
        grp     <= wr_data[5:4];
        first   <= wr_data[CHW-1:0];
      end
      div_cnt <= (!start_q || cclk_en) ? 5'd0 : div_cnt + 5'd1;
      if (stop) begin
        start_q <= 1'b0; busy_q <= 1'b0; pos <= '0;
      end else if (go) begin
        start_q <= 1'b1; busy_q <= 1'b0; pos <= '0;
        done_flags <= '0;
      end else if (start_q) begin
        if (!busy_q) busy_q <= 1'b1;
        else if (conv_done) begin
          busy_q              <= 1'b0;
          res[conv_ch]        <= conv_data;
          done_flags[conv_ch] <= 1'b1;
          if (last) begin
            pos <= '0;
            if (!(scan_en && cont)) start_q <= 1'b0;
          end else pos <= pos + 2'd1;
        end
      end
    end
  end

endmodule

module adc_scan_seq_chk #(
  parameter int NCH = 16,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           standby,
  input logic           wr_en,
  input logic [7:0]     ctrl_q,
  input logic [7:0]     mode_q,
  input logic           cclk_en,
  input logic           conv_start,
  input logic [CHW-1:0] conv_ch,
  input logic           conv_done,
  input logic           busy_q,
  input logic [NCH-1:0] done_flags
);

  p_start_pulse_r13: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start);

  p_standby_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    standby |=> !ctrl_q[4]);

  p_idle_no_cclk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[4] |-> !cclk_en);

  p_locked_cfg_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[4] |=> (ctrl_q[6:5] == $past(ctrl_q[6:5])) && (ctrl_q[3] == $past(ctrl_q[3]))
                  && (mode_q == $past(mode_q)));

  p_trig_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[7] && !ctrl_q[4] && !standby && !wr_en) |=> !ctrl_q[4]);

  p_single_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[4] && busy_q && conv_done && !mode_q[7] && !standby && !wr_en) |=> !ctrl_q[4]);

  p_flag_set_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[4] && busy_q && conv_done && !standby && !wr_en) |=> done_flags[$past(conv_ch)]);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .standby(standby), .wr_en(wr_en),
  .ctrl_q(ctrl_q), .mode_q(mode_q), .cclk_en(cclk_en),
  .conv_start(conv_start), .conv_ch(conv_ch), .conv_done(conv_done),
  .busy_q(busy_q), .done_flags(done_flags)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CONV = 4;

  logic clk = 0, rst_n = 0, standby = 0, wr_en = 0, wr_sel = 0;
  logic [7:0] wr_data = 0;
  logic ext_trig = 0, tmr_trig = 0, conv_done = 0;
  logic [9:0] conv_data = 0;
  logic [3:0] rd_ch = 0;
  logic [7:0] ctrl_q, mode_q;
  logic cclk_en, conv_start;
  logic [3:0] conv_ch;
  logic [9:0] rd_data;
  logic [15:0] done_flags;

  adc_scan_seq u_adc_scan_seq (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(bit ok, string tag, int got, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  // fixed-latency converter
  int cv_cnt = 0, seqn = 0;
  logic [3:0] cv_ch = 0;
  int cv_res [16];
  always @(negedge clk) begin
    conv_done = 0;
    if (!ctrl_q[4]) cv_cnt = 0;
    else if (conv_start) begin cv_cnt = CONV; cv_ch = conv_ch; end
    else if (cv_cnt > 0 && cclk_en) begin
      cv_cnt--;
      if (cv_cnt == 0) begin
        conv_done = 1;
        conv_data = 10'((int'(cv_ch) * 37 + seqn * 11) & 1023);
        cv_res[cv_ch] = int'(conv_data);
        seqn++;
      end
    end
  end

  // behavioural reference model
  bit m_trg, m_start, m_cont, m_scan, m_busy;
  int m_cks, m_grp, m_first, m_pos, m_cnt;
  int m_res [16];
  logic [15:0] m_flags;
  bit s0, wc, wm, stp, go, cc;
  int ch, gl;
  int chq [$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_trg = 0; m_start = 0; m_cont = 0; m_scan = 0; m_busy = 0;
      m_cks = 0; m_grp = 0; m_first = 0; m_pos = 0; m_cnt = 0; m_flags = 0;
      foreach (m_res[i]) m_res[i] = 0;
    end else begin
      s0  = m_start;
      wc  = wr_en && !wr_sel;
      wm  = wr_en && wr_sel;
      stp = standby || (wc && !wr_data[4]);
      go  = !stp && !m_start && ((wc && wr_data[4]) || (m_trg && (ext_trig || tmr_trig)));
      cc  = m_start && (m_cnt == (32 >> m_cks) - 1);
      m_cnt = (!m_start || cc) ? 0 : m_cnt + 1;
      ch = (m_first + m_pos) % 16;
      gl = m_scan ? m_grp : 0;
      if (stp) begin m_start = 0; m_busy = 0; m_pos = 0; end
      else if (go) begin m_start = 1; m_busy = 0; m_pos = 0; m_flags = 0; end
      else if (m_start) begin
        if (!m_busy) m_busy = 1;
        else if (conv_done) begin
          m_busy = 0; m_res[ch] = int'(conv_data); m_flags[ch] = 1;
          if (m_pos == gl) begin m_pos = 0; if (!(m_scan && m_cont)) m_start = 0; end
          else m_pos++;
        end
      end
      if (wc) begin
        m_trg = wr_data[7];
        if (!s0) begin m_cks = int'(wr_data[6:5]); m_cont = wr_data[3]; end
      end
      if (wm && !s0) begin
        m_scan = wr_data[7]; m_grp = int'(wr_data[5:4]); m_first = int'(wr_data[3:0]);
      end
    end
    #1;
    tests++;
    if (ctrl_q !== {m_trg, 2'(m_cks), m_start, m_cont, 3'b111}) begin
      fails++; $display("FAIL R5 ctrl at %0t: got %0h expected %0h", $time, ctrl_q,
                        {m_trg, 2'(m_cks), m_start, m_cont, 3'b111});
    end
    if (mode_q !== {m_scan, 1'b0, 2'(m_grp), 4'(m_first)}) begin
      fails++; $display("FAIL R12 mode at %0t: got %0h expected %0h", $time, mode_q,
                        {m_scan, 1'b0, 2'(m_grp), 4'(m_first)});
    end
    if (done_flags !== m_flags) begin
      fails++; $display("FAIL R11 flags at %0t: got %0h expected %0h", $time, done_flags, m_flags);
    end
    if (conv_start !== (m_start && !m_busy)) begin
      fails++; $display("FAIL R13 conv_start at %0t: got %0b expected %0b", $time, conv_start,
                        m_start && !m_busy);
    end
    if (cclk_en !== (m_start && m_cnt == (32 >> m_cks) - 1)) begin
      fails++; $display("FAIL R3 cclk_en at %0t: got %0b expected %0b", $time, cclk_en,
                        m_start && m_cnt == (32 >> m_cks) - 1);
    end
    if (conv_start && conv_ch !== 4'((m_first + m_pos) % 16)) begin
      fails++; $display("FAIL R7 conv_ch at %0t: got %0h expected %0h", $time, conv_ch,
                        (m_first + m_pos) % 16);
    end
    if (int'(rd_data) != m_res[rd_ch]) begin
      fails++; $display("FAIL R11 rd_data at %0t: got %0h expected %0h", $time, rd_data, m_res[rd_ch]);
    end
    if (conv_start) chq.push_back(int'(conv_ch));
  end

  task automatic wr(bit sel, logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && ctrl_q[4]; i++) @(negedge clk);
  endtask

  task automatic cclk_gap(output int gap);
    gap = 0;
    while (!cclk_en) @(negedge clk);
    @(negedge clk);
    gap = 1;
    while (!cclk_en && gap < 100) begin @(negedge clk); gap++; end
  endtask

  task automatic chk_seq(string tag, int exp [$]);
    chk(chq.size() == exp.size(), tag, chq.size(), exp.size());
    for (int i = 0; i < exp.size() && i < chq.size(); i++)
      chk(chq[i] == exp[i], tag, chq[i], exp[i]);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int gap;
    logic [15:0] fl;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(ctrl_q == 8'h07, "R1 ctrl reset", ctrl_q, 8'h07);
    chk(mode_q == 8'h00, "R1 mode reset", mode_q, 0);
    chk(done_flags == 0, "R1 flags reset", done_flags, 0);

    wr(0, 8'h60);
    chk(ctrl_q == 8'h67, "R2 reserved bits", ctrl_q, 8'h67);

    // R6 single channel 5
    wr(1, 8'h05); chq.delete();
    wr(0, 8'h70);
    wait_idle();
    chk_seq("R6 single seq", '{5});
    chk(done_flags == 16'h0020, "R6 flags", done_flags, 16'h0020);
    rd_ch = 5; #1;
    chk(int'(rd_data) == cv_res[5], "R11 result ch5", rd_data, cv_res[5]);

    // R9 cont bit without scan
    wr(1, 8'h03); chq.delete();
    wr(0, 8'h58);
    wait_idle();
    chk_seq("R9 single with cont", '{3});
    chk(ctrl_q[4] == 0, "R9 stopped", ctrl_q[4], 0);

    // R7 one-pass scan with wrap
    wr(1, 8'hBE); chq.delete();
    chk(mode_q == 8'hBE, "R12 mode layout", mode_q, 8'hBE);
    wr(0, 8'h30);
    wait_idle();
    chk_seq("R7 scan order", '{14, 15, 0, 1});
    chk(done_flags == 16'hC003, "R7 flags", done_flags, 16'hC003);
    rd_ch = 15; #1;
    chk(int'(rd_data) == cv_res[15], "R11 result ch15", rd_data, cv_res[15]);

    // R8 continuous scan, R3 divide by 32, R10 locks
    wr(1, 8'h93); chq.delete();
    wr(0, 8'h18);
    cclk_gap(gap);
    chk(gap == 32, "R3 div32", gap, 32);
    wr(0, 8'h78);
    chk(ctrl_q[6:5] == 2'b00, "R10 cks locked", ctrl_q[6:5], 0);
    wr(1, 8'h05);
    chk(mode_q == 8'h93, "R10 mode locked", mode_q, 8'h93);
    for (int i = 0; i < 20000 && chq.size() < 5; i++) @(negedge clk);
    chk_seq("R8 repeat order", '{3, 4, 3, 4, 3});
    chk(ctrl_q[4] == 1, "R8 still running", ctrl_q[4], 1);
    wr(0, 8'h98);
    fl = done_flags;
    @(negedge clk); ext_trig = 1; @(negedge clk); ext_trig = 0; @(negedge clk);
    chk(done_flags == fl && fl != 0, "R4 trigger during run ignored", done_flags, fl);
    standby = 1; @(negedge clk); standby = 0;
    chk(ctrl_q[4] == 0, "R8 standby clears", ctrl_q[4], 0);

    // R5 software stop, R3 divide by 4
    wr(0, 8'h78); chq.delete();
    cclk_gap(gap);
    chk(gap == 4, "R3 div4", gap, 4);
    wr(0, 8'h68);
    chk(ctrl_q[4] == 0 && conv_start == 0, "R5 immediate stop", ctrl_q[4], 0);
    chq.delete();
    repeat (200) @(negedge clk);
    chk(chq.size() == 0, "R5 no start after stop", chq.size(), 0);

    // R4 triggers
    wr(1, 8'h09);
    wr(0, 8'h80);
    ext_trig = 1; @(negedge clk); ext_trig = 0;
    chk(ctrl_q[4] == 1, "R4 ext trigger starts", ctrl_q[4], 1);
    wait_idle();
    chk(done_flags == 16'h0200, "R4 R11 flags after trigger run", done_flags, 16'h0200);
    tmr_trig = 1; @(negedge clk); tmr_trig = 0;
    chk(ctrl_q[4] == 1, "R4 timer trigger starts", ctrl_q[4], 1);
    wait_idle();
    wr(0, 8'h00);
    ext_trig = 1; tmr_trig = 1; @(negedge clk); ext_trig = 0; tmr_trig = 0;
    repeat (5) @(negedge clk);
    chk(ctrl_q[4] == 0, "R4 disabled triggers ignored", ctrl_q[4], 0);
    rd_ch = 9; #1;
    chk(int'(rd_data) == cv_res[9], "R11 result ch9", rd_data, cv_res[9]);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule